// File: doc/BRIEF.md
# Link-Side PHY Byte Interface Controller

This block sits on the link side of an 8-bit, clock-synchronous interface to an external transceiver PHY. The PHY supplies the clock and owns two inputs to the block: a direction line that decides who may use the shared data bus, and a throttle line that paces bytes. The block owns a one-cycle stop line and the data bus in the cycles it is allowed to drive. The pad tristate is left to the chip, so the bus appears as a separate input, output and output enable.

On the transmit side, local logic hands over packets through a ready/valid byte stream with a last flag. The first byte of each packet is the transmit command and must be non-zero. A one-entry prefetch register always holds the next byte, so the byte after an accepted one reaches the bus on the following clock. There is no path from the throttle pin to the bus. If the PHY takes the bus in the middle of a packet, the block reports an abort and discards the rest of that packet.

On the receive side, bytes that the PHY marks valid are handed on with a one-cycle valid strobe. An end-of-packet strobe follows when the PHY gives the bus back.

Top module: `phy_link_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `bus_out` is zero, `bus_oe` follows R2, `tx_ready` is high, and `phy_stop`, `tx_abort`, `rx_valid` and `rx_eop` are low.
- R2: `bus_oe` is high only in a cycle where `phy_dir` is low now and was also low at the previous clock edge. It is therefore low while the PHY drives and during the single turnaround cycle after either change of `phy_dir`.
- R3: Each packet's bytes are accepted by the PHY in the order they were offered. A byte counts as accepted when it is on `bus_out` with `bus_oe` high and `phy_thr` high. The first byte of the packet is the command.
- R4: A zero byte offered at the head of a packet is consumed and never driven. The byte after it becomes the head. A lone zero byte flagged last produces no bus activity and no stop.
- R5: A byte on the bus that is not accepted stays unchanged in the next cycle, unless the PHY has raised `phy_dir`.
- R6: Under a continuously high throttle, a packet of N bytes is delivered one byte per cycle. Its stop appears N+3 cycles after the first byte is offered on an empty stream.
- R7: In the cycle after the last byte of a packet is accepted, `phy_stop` is high for exactly one cycle. `bus_out` is zero in that cycle and in the next one.
- R8: If `phy_dir` rises while a packet is on the bus and its stop has not yet come, `tx_abort` pulses for one cycle in the next cycle. That packet gets no stop, its remaining bytes are drained from the stream, and the next packet is sent normally.
- R9: When `phy_dir` is high both now and at the previous edge and `phy_thr` is high, the bus byte appears on `rx_data` with a one-cycle `rx_valid` in the next cycle.
- R10: No byte is captured in the first cycle of `phy_dir` high (turnaround), nor in a cycle where `phy_thr` is low.
- R11: When `phy_dir` is first seen low after a receive that captured at least one byte, `rx_eop` pulses for one cycle in the next cycle. A receive with no captured byte gives no `rx_eop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied interface clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_dir | input | 1 | Bus direction from the PHY: low lets the block drive |
| phy_thr | input | 1 | Throttle from the PHY: accept when transmitting, byte valid when receiving |
| phy_stop | output | 1 | One-cycle end-of-transmit strobe to the PHY |
| bus_in | input | DATA_W | Data bus as seen at the pads |
| bus_out | output | DATA_W | Data the block drives when enabled |
| bus_oe | output | 1 | Output enable for the data pads |
| tx_data | input | DATA_W | Transmit byte from local logic |
| tx_last | input | 1 | Marks the final byte of a packet |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Block takes the byte at this edge when valid |
| tx_abort | output | 1 | One-cycle strobe: packet abandoned because the PHY took the bus |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | One-cycle strobe marking `rx_data` as new |
| rx_eop | output | 1 | One-cycle end-of-receive strobe |

## Verification
The hardest situation to reach is the PHY raising `phy_dir` at the exact point where a packet is live. That includes the command sitting unaccepted, a zero payload byte on the bus, and the last byte accepted with the stop still to come. Each of these needs a different outcome, and the following packet must still start cleanly after the drain. The bench gets there with a directed abort and with random receive bursts injected at random cycles while packets of random length stream under random throttle. Its PHY model decides abort versus stop from what it has seen on the bus, so every collision the random bursts create is scored.

// File: rtl/phy_link_pkg.sv
// Shared types for the PHY byte interface controller.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package phy_link_pkg;

    // Transmit engine states
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,   // nothing on the bus, waiting for a non-zero head
        TX_SEND  = 2'd1,   // a packet byte is on the bus
        TX_STOP  = 2'd2,   // stop strobe cycle, bus at zero
        TX_DRAIN = 2'd3    // discarding the rest of an abandoned packet
    } tx_state_e;

endpackage

// File: rtl/plk_dir_track.sv
// Direction tracker: remembers the direction line from the previous edge
// and derives the drive and sample windows, which exclude the turnaround
// cycle after every change. Assumes phy_dir is synchronous to clk.
module plk_dir_track (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_i,
    output logic drive_ok,
    output logic rx_ok,
    output logic dir_fall
);

    logic dir_q;

    // Register the direction seen at each edge
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= 1'b0;
        else        dir_q <= dir_i;
    end

    // Windows: both cycles the same value means no turnaround
    always_comb begin
        drive_ok = !dir_i && !dir_q;
        rx_ok    =  dir_i &&  dir_q;
        dir_fall = !dir_i &&  dir_q;
    end

endmodule

// File: rtl/plk_prefetch.sv
// One-entry prefetch register between the local byte stream and the
// transmit engine. It keeps the next byte ready so the engine can put it
// on the bus at the edge that accepts the current one. Assumes take is
// only raised while the entry is valid.
module plk_prefetch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              take,
    output logic              pf_valid,
    output logic [DATA_W-1:0] pf_data,
    output logic              pf_last
);

    // Room when empty or when the held byte leaves at this edge
    always_comb in_ready = !pf_valid || take;

    // Load a new byte or drop the consumed one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_data  <= '0;
            pf_last  <= 1'b0;
        end else if (in_ready) begin
            pf_valid <= in_valid;
            if (in_valid) begin
                pf_data <= in_data;
                pf_last <= in_last;
            end
        end
    end

endmodule

// File: rtl/plk_tx_engine.sv
// Transmit engine: starts packets with the non-zero head byte, advances
// one byte per throttle-accept from the prefetch register, raises a
// one-cycle stop after the last byte, and abandons the packet when the
// PHY takes the bus. All bus and strobe outputs come from flops.
// Assumes the local stream keeps up once a packet has started. If the
// prefetch register is empty at an accept, the packet ends there.
module plk_tx_engine
    import phy_link_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_i,
    input  logic              thr_i,
    input  logic              drive_ok,
    input  logic              pf_valid,
    input  logic [DATA_W-1:0] pf_data,
    input  logic              pf_last,
    output logic              take,
    output logic [DATA_W-1:0] bus_q,
    output logic              stop_q,
    output logic              abort_q
);

    tx_state_e st;
    logic      cur_last;
    logic      accept, advance, head_zero, start, abort, drain_pop;

    // Decode this cycle's events from state and PHY inputs
    always_comb begin
        accept    = (st == TX_SEND) && thr_i && !dir_i;
        advance   = accept && !cur_last && pf_valid;
        abort     = (st == TX_SEND) && dir_i;
        head_zero = (st == TX_IDLE) && pf_valid && (pf_data == '0);
        start     = (st == TX_IDLE) && pf_valid && (pf_data != '0) && drive_ok;
        drain_pop = (st == TX_DRAIN) && pf_valid;
        take      = head_zero || start || advance || drain_pop;
    end

    // State, bus byte and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= TX_IDLE;
            bus_q    <= '0;
            cur_last <= 1'b0;
            stop_q   <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            stop_q  <= 1'b0;
            abort_q <= 1'b0;
            case (st)
                TX_IDLE: begin
                    if (start) begin
                        bus_q    <= pf_data;
                        cur_last <= pf_last;
                        st       <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (abort) begin
                        bus_q   <= '0;
                        abort_q <= 1'b1;
                        st      <= cur_last ? TX_IDLE : TX_DRAIN;
                    end else if (advance) begin
                        bus_q    <= pf_data;
                        cur_last <= pf_last;
                    end else if (accept) begin
                        bus_q  <= '0;
                        stop_q <= 1'b1;
                        st     <= TX_STOP;
                    end
                end
                TX_STOP: begin
                    st <= TX_IDLE;
                end
                TX_DRAIN: begin
                    if (drain_pop && pf_last) st <= TX_IDLE;
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/plk_rx_capture.sv
// Receive capture: registers bytes the PHY marks valid outside the
// turnaround cycle, and flags end of packet when the PHY releases the bus
// after at least one captured byte. Assumes the window inputs come from
// the direction tracker.
module plk_rx_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_ok,
    input  logic              dir_fall,
    input  logic              thr_i,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] data_q,
    output logic              valid_q,
    output logic              eop_q
);

    logic seen;
    logic grab;

    // A byte is taken only inside the receive window with throttle high
    always_comb grab = rx_ok && thr_i;

    // Capture the byte, strobe valid and end of packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            eop_q   <= 1'b0;
            seen    <= 1'b0;
        end else begin
            valid_q <= grab;
            if (grab) data_q <= din;
            eop_q <= dir_fall && seen;
            if (dir_fall)  seen <= 1'b0;
            else if (grab) seen <= 1'b1;
        end
    end

endmodule

// File: rtl/phy_link_ctrl.sv
// Link-side controller for an 8-bit shared-bus PHY interface. It wires the
// direction tracker, the prefetch register, the transmit engine and the
// receive capture. Assumes clk is the PHY clock and the pads are built
// outside from bus_out and bus_oe.
module phy_link_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_dir,
    input  logic              phy_thr,
    output logic              phy_stop,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_last,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_abort,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_eop
);

    logic              drive_ok, rx_ok, dir_fall;
    logic              take, pf_valid, pf_last;
    logic [DATA_W-1:0] pf_data;

    plk_dir_track u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_i    (phy_dir),
        .drive_ok (drive_ok),
        .rx_ok    (rx_ok),
        .dir_fall (dir_fall)
    );

    plk_prefetch #(.DATA_W(DATA_W)) u_pf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (tx_data),
        .in_last  (tx_last),
        .in_valid (tx_valid),
        .in_ready (tx_ready),
        .take     (take),
        .pf_valid (pf_valid),
        .pf_data  (pf_data),
        .pf_last  (pf_last)
    );

    plk_tx_engine #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_i    (phy_dir),
        .thr_i    (phy_thr),
        .drive_ok (drive_ok),
        .pf_valid (pf_valid),
        .pf_data  (pf_data),
        .pf_last  (pf_last),
        .take     (take),
        .bus_q    (bus_out),
        .stop_q   (phy_stop),
        .abort_q  (tx_abort)
    );

    plk_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_ok    (rx_ok),
        .dir_fall (dir_fall),
        .thr_i    (phy_thr),
        .din      (bus_in),
        .data_q   (rx_data),
        .valid_q  (rx_valid),
        .eop_q    (rx_eop)
    );

    // Pads are enabled only outside turnaround with the bus granted
    always_comb bus_oe = drive_ok;

endmodule

// File: rtl/phy_link_ctrl_chk.sv
// Protocol checker for phy_link_ctrl, attached by bind. It watches only
// the top-level ports.
module phy_link_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phy_dir,
    input logic              phy_thr,
    input logic              phy_stop,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_oe,
    input logic              tx_abort,
    input logic              rx_valid,
    input logic              rx_eop
);

    p_oe_phy_owns_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phy_dir |-> !bus_oe);

    p_oe_turnaround_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!phy_dir && $past(phy_dir)) |-> !bus_oe);

    p_hold_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !phy_thr && !phy_stop && bus_out != '0) |=> (phy_dir || $stable(bus_out)));

    p_stop_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phy_stop |=> !phy_stop);

    p_stop_bus_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phy_stop |-> bus_out == '0);

    p_abort_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort);

    p_abort_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> !phy_stop);

    p_rx_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(phy_dir) && $past(phy_thr)));

    p_rx_no_turn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(phy_dir, 2));

    p_eop_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eop |-> (!$past(phy_dir) && !rx_valid));

endmodule

bind phy_link_ctrl phy_link_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phy_dir  (phy_dir),
    .phy_thr  (phy_thr),
    .phy_stop (phy_stop),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .tx_abort (tx_abort),
    .rx_valid (rx_valid),
    .rx_eop   (rx_eop)
);

// File: tb/phy_link_ctrl_test.sv
`timescale 1ns/1ps
module phy_link_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phy_dir = 1'b0, phy_thr = 1'b0;
    logic [7:0] bus_in = '0, tx_data = '0;
    logic       tx_last = 1'b0, tx_valid = 1'b0;
    logic       phy_stop, bus_oe, tx_ready, tx_abort, rx_valid, rx_eop;
    logic [7:0] bus_out, rx_data;

    phy_link_ctrl #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .phy_dir(phy_dir), .phy_thr(phy_thr),
        .phy_stop(phy_stop), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .tx_data(tx_data), .tx_last(tx_last), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_abort(tx_abort), .rx_data(rx_data), .rx_valid(rx_valid), .rx_eop(rx_eop)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [8:0] src_q[$];
    logic [8:0] exp_q[$];
    bit prev_dir = 0, prev_stop = 0, prev_hold = 0, in_pkt = 0, seen = 0;
    logic [7:0] prev_bus = '0;
    bit e_stop = 0, e_abort = 0, e_rxv = 0, e_eop = 0;
    logic [7:0] e_rxd = '0;
    int tick_no = 0, last_stop_tick = 0, n_stop = 0, n_abort = 0, n_rxv = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit f_oe(bit d, bit pd);
        return !d && !pd;
    endfunction

    function automatic bit f_rx_take(bit d, bit pd, bit n);
        return d && pd && n;
    endfunction

    function automatic bit f_eop(bit d, bit pd, bit s);
        return !d && pd && s;
    endfunction

    // PHY model and scoreboard, evaluated at the falling edge
    task automatic monitor();
        logic [8:0] t;
        bool_checks: begin
            check("R2 bus_oe", int'(bus_oe), int'(f_oe(phy_dir, prev_dir)));
            check("R7 stop timing", int'(phy_stop), int'(e_stop));
            check("R8 abort strobe", int'(tx_abort), int'(e_abort));
            check("R9 R10 rx_valid", int'(rx_valid), int'(e_rxv));
            if (e_rxv) check("R9 rx_data", int'(rx_data), int'(e_rxd));
            check("R11 rx_eop", int'(rx_eop), int'(e_eop));
            if (phy_stop)  check("R7 bus zero in stop", int'(bus_out), 0);
            if (prev_stop) check("R7 bus zero after stop", int'(bus_out), 0);
            if (prev_hold && !phy_dir) check("R5 byte held", int'(bus_out), int'(prev_bus));
        end
        if (phy_stop) begin n_stop++; last_stop_tick = tick_no; end
        if (tx_abort) n_abort++;
        if (rx_valid) n_rxv++;
        e_stop = 0; e_abort = 0;
        if (phy_stop) begin
            in_pkt = 0;
        end else if (phy_dir && !prev_dir && (in_pkt || bus_out != 8'h00)) begin
            e_abort = 1; in_pkt = 0;
            while (exp_q.size() != 0) begin
                t = exp_q.pop_front();
                if (t[8]) break;
            end
        end else if (bus_oe && phy_thr && (in_pkt || bus_out != 8'h00)) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected byte", 1, 0);
            end else begin
                t = exp_q.pop_front();
                check("R3 accepted byte", int'(bus_out), int'(t[7:0]));
                in_pkt = 1;
                if (t[8]) e_stop = 1;
            end
        end
        e_rxv = f_rx_take(phy_dir, prev_dir, phy_thr);
        e_rxd = bus_in;
        e_eop = f_eop(phy_dir, prev_dir, seen);
        if (!phy_dir && prev_dir) seen = 0;
        else if (e_rxv) seen = 1;
        if (tx_valid && tx_ready) void'(src_q.pop_front());
        prev_hold = bus_oe && !phy_thr && !phy_stop && (in_pkt || bus_out != 8'h00);
        prev_dir  = phy_dir;
        prev_stop = phy_stop;
        prev_bus  = bus_out;
    endtask

    task automatic tick(input bit d, input bit n, input logic [7:0] din);
        @(posedge clk);
        #1;
        phy_dir = d; phy_thr = n; bus_in = din;
        tx_valid = (src_q.size() != 0);
        if (tx_valid) {tx_last, tx_data} = src_q[0];
        else          {tx_last, tx_data} = 9'h000;
        tick_no++;
        @(negedge clk);
        monitor();
    endtask

    task automatic push_byte(input bit last, input logic [7:0] b, input bit expect_it);
        src_q.push_back({last, b});
        if (expect_it) exp_q.push_back({last, b});
    endtask

    task automatic push_pkt(input int len);
        push_byte(len == 1, 8'(1 + ($urandom % 255)), 1);
        for (int i = 1; i < len; i++) push_byte(i == len - 1, 8'($urandom), 1);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        int base, s0, a0, r0, burst, guard;
        void'($urandom(32'd7341));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 bus_out", int'(bus_out), 0);
        check("R1 stop", int'(phy_stop), 0);
        check("R1 abort", int'(tx_abort), 0);
        check("R1 rx_valid", int'(rx_valid), 0);
        check("R1 rx_eop", int'(rx_eop), 0);
        check("R1 tx_ready", int'(tx_ready), 1);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check("R1 bus_oe after reset", int'(bus_oe), 1);

        // R6: continuous throttle, four-byte packet, stop at tick 7
        push_byte(0, 8'h41, 1); push_byte(0, 8'h00, 1);
        push_byte(0, 8'h7E, 1); push_byte(1, 8'h81, 1);
        base = tick_no;
        repeat (9) tick(0, 1, 8'h00);
        check("R6 stop cycle", last_stop_tick - base, 7);
        check("R3 packet drained", exp_q.size(), 0);

        // R4: zero head before a packet, then a lone zero flagged last
        s0 = n_stop;
        push_byte(0, 8'h00, 0); push_byte(0, 8'h22, 1); push_byte(1, 8'h33, 1);
        repeat (8) tick(0, 1, 8'h00);
        check("R4 packet after zero head", n_stop - s0, 1);
        s0 = n_stop;
        push_byte(1, 8'h00, 0);
        repeat (6) tick(0, 1, 8'h00);
        check("R4 lone zero gives no stop", n_stop - s0, 0);
        check("R4 lone zero consumed", src_q.size(), 0);

        // R9 R10 R11: receive with a valid-marked turnaround byte
        r0 = n_rxv;
        tick(1, 1, 8'hAA);
        tick(1, 1, 8'h5C);
        tick(1, 0, 8'h11);
        tick(1, 1, 8'hC3);
        tick(0, 0, 8'h00);
        tick(0, 0, 8'h00);
        check("R10 only two bytes captured", n_rxv - r0, 2);
        tick(1, 1, 8'h99);
        tick(0, 0, 8'h00);
        tick(0, 0, 8'h00);
        check("R11 no eop without bytes", n_rxv - r0, 2);

        // R8: PHY takes the bus mid-packet, next packet still goes out
        a0 = n_abort; s0 = n_stop;
        push_byte(0, 8'h5A, 1); push_byte(0, 8'h01, 1); push_byte(0, 8'h02, 1);
        push_byte(0, 8'h03, 1); push_byte(0, 8'h04, 1); push_byte(1, 8'h05, 1);
        repeat (3) tick(0, 0, 8'h00);
        repeat (2) tick(0, 1, 8'h00);
        tick(1, 0, 8'h00); tick(1, 1, 8'h6D); tick(1, 0, 8'h00);
        tick(0, 0, 8'h00); tick(0, 0, 8'h00);
        check("R8 one abort", n_abort - a0, 1);
        check("R8 no stop for aborted packet", n_stop - s0, 0);
        push_byte(0, 8'h77, 1); push_byte(1, 8'h88, 1);
        repeat (12) tick(0, 1, 8'h00);
        check("R8 next packet completes", n_stop - s0, 1);
        check("R8 expected bytes all seen", exp_q.size(), 0);

        // R3 R5 R7 R8 R9 R11: random traffic with random receive bursts
        for (int b = 0; b < 3; b++) begin
            for (int p = 0; p < 10; p++) begin
                if (p % 4 == 0) push_byte(0, 8'h00, 0);
                push_pkt(1 + int'($urandom % 8));
            end
            burst = 0; guard = 0;
            while ((src_q.size() != 0 || exp_q.size() != 0 || in_pkt) && guard < 4000) begin
                guard++;
                if (burst > 0) begin
                    tick(1, 1'($urandom), 8'($urandom)); burst--;
                end else if ($urandom % 12 == 0) begin
                    burst = 1 + int'($urandom % 5);
                    tick(1, 1'($urandom), 8'($urandom));
                end else begin
                    tick(0, ($urandom % 3) != 0, 8'h00);
                end
            end
            repeat (4) tick(0, 0, 8'h00);
            check("R3 random batch delivered", exp_q.size(), 0);
        end
        finish_run();
    end

endmodule